// File: doc/BRIEF.md
# Dual-Register Bank Test Access Controller

This block wraps a bank of dual-register cells (24 by default, each holding a first register Q1 and a second, buried register Q2) with test access logic. In normal operation each cell loads its two functional next-state inputs on the clock whenever the functional enable is high. Each cell output shows Q1 through a per-cell polarity inversion, gated to zero when that cell's output enable is low.

Test access has two modes. In preload, a rising edge of the preload strobe copies a 12-bit pin data word into one group of 12 registers. Two select bits pick the group: Q1 or Q2, in even or odd cells. In observe, each enabled output shows Q2 instead of Q1. A security lock blocks both modes as soon as it is raised. It then stays in force until reset.

A small mode machine has four states:
- FUNC: normal operation.
- PRELOAD: writes are armed and functional loads are frozen.
- OBSERVE: Q2 is routed to the outputs.
- LOCKED: absorbing state.

The next state is worked out on every clock edge, in this priority order:
1. LOCKED if the machine is already LOCKED or the lock input is high.
2. Otherwise PRELOAD if the preload mode input is high.
3. Otherwise OBSERVE if the observe mode input is high.
4. Otherwise FUNC.

The transitions are FUNC/OBSERVE/PRELOAD to one another by mode input, any state to LOCKED on lock, and LOCKED to FUNC only through reset.

Top module: `regbank_testport`

## Requirements
- R1: While reset is low and after it is released, all registers are 0 and the mode is FUNC, so pin_out is 0 for every cell with pol_in 0.
- R2: Outside PRELOAD, a clock edge with func_en high loads d1_in[i] into Q1 and d2_in[i] into Q2. In FUNC, pin_out[i] = oe_in[i] ? Q1[i]^pol_in[i] : 0.
- R3: The mode becomes PRELOAD one clock after preload_mode is seen high. In PRELOAD, the first clock edge at which strobe is high after having been low at the previous edge writes pin_data[k] into cell 2k+eo_sel. qsel picks the target register: 0 selects Q1 and 1 selects Q2.
- R4: During a preload write, every register outside the selected group keeps its value. In PRELOAD, func_en has no effect on any register.
- R5: The value written by preload is pin_data itself, independent of pol_in.
- R6: The mode becomes OBSERVE one clock after observe_mode is seen high with preload_mode low. In OBSERVE, pin_out[i] = oe_in[i] ? Q2[i]^pol_in[i] : 0.
- R7: With preload_mode and observe_mode both high, the mode is PRELOAD and Q2 is not routed to the outputs.
- R8: A high lock_in blocks a preload write at that same edge. It also returns the outputs to showing Q1 in the same cycle, before any clock edge.
- R9: Once lock_in has been seen high at a clock edge, preload and observe stay blocked after lock_in falls, until reset. After reset both work again.
- R10: A strobe held high for several edges writes only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| func_en | input | 1 | Functional load enable |
| d1_in | input | NCELL | Functional next-state for Q1 |
| d2_in | input | NCELL | Functional next-state for Q2 |
| oe_in | input | NCELL | Per-cell output enable |
| pol_in | input | NCELL | Per-cell output inversion |
| preload_mode | input | 1 | Preload mode request |
| observe_mode | input | 1 | Q2 observe mode request |
| qsel | input | 1 | Preload target: 0 Q1, 1 Q2 |
| eo_sel | input | 1 | Preload target: 0 even cells, 1 odd cells |
| strobe | input | 1 | Preload strobe, acts on its rising edge |
| pin_data | input | NCELL/2 | Preload data word, bit k to k-th cell of the group |
| lock_in | input | 1 | Security lock request |
| pin_out | output | NCELL | Cell outputs |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a lock request and a preload strobe edge. The bench raises lock_in at the same falling edge that raises strobe. It then confirms through the Q1 outputs that nothing was written.

The second pair is a lock request and observe. The bench raises lock_in while in OBSERVE and samples the outputs before the next clock edge, expecting Q1 to show at once.

Random stimulus also asserts both mode requests together with strobe edges. A bench model that gives preload priority judges every cycle.

// File: rtl/rbtp_pkg.sv
package rbtp_pkg;
    typedef enum logic [1:0] {
        ST_FUNC    = 2'd0,
        ST_PRELOAD = 2'd1,
        ST_OBSERVE = 2'd2,
        ST_LOCKED  = 2'd3
    } mode_e;
endpackage

// File: rtl/rbtp_mode_fsm.sv
module rbtp_mode_fsm
    import rbtp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic preload_mode,
    input  logic observe_mode,
    input  logic strobe,
    input  logic lock_in,
    output logic wr_en,
    output logic hold,
    output logic obs_on
);
    mode_e state, state_nx;
    logic  strobe_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_FUNC;
            strobe_q <= 1'b0;
        end else begin
            state    <= state_nx;
            strobe_q <= strobe;
        end
    end

    // transitions: lock first, then preload over observe
    always_comb begin
        if (state == ST_LOCKED || lock_in)
            state_nx = ST_LOCKED;
        else if (preload_mode)
            state_nx = ST_PRELOAD;
        else if (observe_mode)
            state_nx = ST_OBSERVE;
        else
            state_nx = ST_FUNC;
    end

    // outputs; lock_in gates both test paths with no clock delay
    always_comb begin
        wr_en  = 1'b0;
        hold   = 1'b0;
        obs_on = 1'b0;
        unique case (state)
            ST_FUNC:    ;
            ST_PRELOAD: begin
                hold  = 1'b1;
                wr_en = strobe && !strobe_q && !lock_in;
            end
            ST_OBSERVE: obs_on = !lock_in;
            ST_LOCKED:  ;
            default:    ;
        endcase
    end

    a_r9_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |=> (state == ST_LOCKED));

    a_r7_preload_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (preload_mode && observe_mode && !lock_in && state != ST_LOCKED)
        |=> (state == ST_PRELOAD && !obs_on));

    a_r8_no_write_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCKED) |-> (!wr_en && !obs_on));

    a_r10_single_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> !wr_en);
endmodule

// File: rtl/rbtp_cell.sv
module rbtp_cell #(
    parameter int GRP = 12,
    parameter int IDX = 0
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           hold,
    input  logic           func_en,
    input  logic           qsel,
    input  logic           eo_sel,
    input  logic [GRP-1:0] pin_data,
    input  logic           d1,
    input  logic           d2,
    output logic           q1,
    output logic           q2
);
    localparam int   K       = IDX / 2;
    localparam logic PAR_BIT = ((IDX % 2) == 1);

    logic in_grp, sel_q1, sel_q2;

    assign in_grp = (eo_sel == PAR_BIT);
    assign sel_q1 = wr_en && in_grp && !qsel;
    assign sel_q2 = wr_en && in_grp &&  qsel;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q1 <= 1'b0;
            q2 <= 1'b0;
        end else begin
            if (sel_q1)
                q1 <= pin_data[K];
            else if (!hold && func_en)
                q1 <= d1;
            if (sel_q2)
                q2 <= pin_data[K];
            else if (!hold && func_en)
                q2 <= d2;
        end
    end

    a_r4_q1_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !sel_q1) |=> (q1 == $past(q1)));

    a_r4_q2_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !sel_q2) |=> (q2 == $past(q2)));

    a_r3_q1_load: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q1 |=> (q1 == $past(pin_data[K])));

    a_r3_q2_load: assert property (@(posedge clk) disable iff (!rst_n)
        sel_q2 |=> (q2 == $past(pin_data[K])));
endmodule

// File: rtl/rbtp_outmux.sv
module rbtp_outmux #(
    parameter int NCELL = 24
) (
    input  logic [NCELL-1:0] q1,
    input  logic [NCELL-1:0] q2,
    input  logic [NCELL-1:0] oe_in,
    input  logic [NCELL-1:0] pol_in,
    input  logic             obs_on,
    output logic [NCELL-1:0] pin_out
);
    for (genvar i = 0; i < NCELL; i++) begin : g_bit
        logic src;
        assign src        = obs_on ? q2[i] : q1[i];
        assign pin_out[i] = oe_in[i] ? (src ^ pol_in[i]) : 1'b0;
    end
endmodule

// File: rtl/regbank_testport.sv
module regbank_testport #(
    parameter int NCELL = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               func_en,
    input  logic [NCELL-1:0]   d1_in,
    input  logic [NCELL-1:0]   d2_in,
    input  logic [NCELL-1:0]   oe_in,
    input  logic [NCELL-1:0]   pol_in,
    input  logic               preload_mode,
    input  logic               observe_mode,
    input  logic               qsel,
    input  logic               eo_sel,
    input  logic               strobe,
    input  logic [NCELL/2-1:0] pin_data,
    input  logic               lock_in,
    output logic [NCELL-1:0]   pin_out
);
    localparam int GRP = NCELL / 2;

    logic             wr_en, hold, obs_on;
    logic [NCELL-1:0] q1, q2;

    rbtp_mode_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .preload_mode (preload_mode),
        .observe_mode (observe_mode),
        .strobe       (strobe),
        .lock_in      (lock_in),
        .wr_en        (wr_en),
        .hold         (hold),
        .obs_on       (obs_on)
    );

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        rbtp_cell #(.GRP(GRP), .IDX(i)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en),
            .hold     (hold),
            .func_en  (func_en),
            .qsel     (qsel),
            .eo_sel   (eo_sel),
            .pin_data (pin_data),
            .d1       (d1_in[i]),
            .d2       (d2_in[i]),
            .q1       (q1[i]),
            .q2       (q2[i])
        );
    end

    rbtp_outmux #(.NCELL(NCELL)) u_out (
        .q1      (q1),
        .q2      (q2),
        .oe_in   (oe_in),
        .pol_in  (pol_in),
        .obs_on  (obs_on),
        .pin_out (pin_out)
    );
endmodule

// File: tb/regbank_testport_tb.sv
module regbank_testport_tb_top;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int N = 24;
    localparam int G = N / 2;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         func_en, preload_mode, observe_mode, qsel, eo_sel, strobe, lock_in;
    logic [N-1:0] d1_in, d2_in, oe_in, pol_in, pin_out;
    logic [G-1:0] pin_data;

    int errs   = 0;
    int checks = 0;
    bit done   = 0;

    // bench model: ms 0 func, 1 preload, 2 observe, 3 locked
    bit [N-1:0] m1, m2;
    int         ms;
    bit         sprev;

    always #2.5 clk = ~clk;

    regbank_testport #(.NCELL(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .func_en(func_en), .d1_in(d1_in), .d2_in(d2_in),
        .oe_in(oe_in), .pol_in(pol_in), .preload_mode(preload_mode),
        .observe_mode(observe_mode), .qsel(qsel), .eo_sel(eo_sel), .strobe(strobe),
        .pin_data(pin_data), .lock_in(lock_in), .pin_out(pin_out)
    );

    function automatic logic [N-1:0] exp_out();
        logic [N-1:0] r;
        bit obs;
        obs = (ms == 2) && !lock_in;
        for (int i = 0; i < N; i++)
            r[i] = oe_in[i] ? ((obs ? m2[i] : m1[i]) ^ pol_in[i]) : 1'b0;
        return r;
    endfunction

    task automatic chk(string req);
        logic [N-1:0] e;
        e = exp_out();
        checks++;
        if (pin_out !== e) begin
            errs++;
            $display("FAIL %s: pin_out=%h expected=%h", req, pin_out, e);
        end
    endtask

    task automatic model_reset();
        m1 = '0; m2 = '0; ms = 0; sprev = 0;
    endtask

    task automatic cycle(string req);
        bit [N-1:0] n1, n2;
        bit wr;
        int nms;
        n1 = m1; n2 = m2;
        wr = (ms == 1) && strobe && !sprev && !lock_in;
        for (int i = 0; i < N; i++) begin
            if (wr) begin
                if ((i % 2) == int'(eo_sel)) begin
                    if (qsel) n2[i] = pin_data[i/2];
                    else      n1[i] = pin_data[i/2];
                end
            end else if (ms != 1 && func_en) begin
                n1[i] = d1_in[i];
                n2[i] = d2_in[i];
            end
        end
        if (ms == 3 || lock_in) nms = 3;
        else if (preload_mode)  nms = 1;
        else if (observe_mode)  nms = 2;
        else                    nms = 0;
        @(posedge clk);
        m1 = n1; m2 = n2; ms = nms; sprev = strobe;
        @(negedge clk);
        chk(req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        chk("R1 in reset");
        rst_n = 1'b1;
        cycle("R1 after reset");
    endtask

    task automatic idle_inputs();
        func_en = 0; preload_mode = 0; observe_mode = 0; qsel = 0; eo_sel = 0;
        strobe = 0; lock_in = 0; d1_in = '0; d2_in = '0; pin_data = '0;
        oe_in = '1; pol_in = '0;
    endtask

    task automatic preload_group(bit qs, bit eo);
        qsel = qs; eo_sel = eo;
        pin_data = G'($urandom);
        pol_in = N'($urandom);
        func_en = 1; d1_in = N'($urandom); d2_in = N'($urandom);
        strobe = 1;
        cycle("R3 R4 R5 preload write");
        strobe = 0;
        cycle("R4 preload hold");
    endtask

    initial begin
        void'($urandom(32'd4711));
        idle_inputs();
        do_reset();

        // R2 functional load
        func_en = 1; d1_in = 24'hA5C3F0; d2_in = 24'h3C0F5A;
        cycle("R2 functional load");
        oe_in = 24'hFF00FF; pol_in = 24'h0F0F0F;
        cycle("R2 oe/pol gating");

        // R3 R4 R5 every group
        oe_in = '1;
        preload_mode = 1; func_en = 0;
        cycle("R3 enter preload");
        for (int g = 0; g < 4; g++) preload_group(g[1], g[0]);

        // R10 strobe held high
        qsel = 0; eo_sel = 1; pin_data = 12'hABC; strobe = 1;
        cycle("R10 first edge");
        for (int j = 0; j < 3; j++) begin
            pin_data = G'($urandom);
            cycle("R10 held strobe");
        end
        strobe = 0;

        // R6 observe shows Q2
        preload_mode = 0; observe_mode = 1; func_en = 0;
        cycle("R6 enter observe");
        pol_in = 24'h123456; oe_in = 24'hF0F0FF;
        cycle("R6 observe gated");

        // R7 both modes
        preload_mode = 1;
        cycle("R7 both modes");
        qsel = 1; eo_sel = 0; pin_data = 12'h5A5; strobe = 1;
        cycle("R7 preload wins write");
        strobe = 0; preload_mode = 0;
        cycle("R7 back to observe");

        // random mix, lock held off
        for (int c = 0; c < 500; c++) begin
            func_en      = ($urandom % 2) == 0;
            d1_in        = N'($urandom);
            d2_in        = N'($urandom);
            oe_in        = N'($urandom);
            pol_in       = N'($urandom);
            preload_mode = ($urandom % 3) == 0;
            observe_mode = ($urandom % 3) == 0;
            qsel         = 1'($urandom);
            eo_sel       = 1'($urandom);
            strobe       = 1'($urandom);
            pin_data     = G'($urandom);
            cycle("R2 R3 R6 R7 random");
        end

        // R8 immediate lock in observe
        idle_inputs();
        observe_mode = 1; oe_in = '1;
        cycle("R6 pre-lock observe");
        cycle("R6 pre-lock observe");
        lock_in = 1;
        #1 chk("R8 immediate observe block");
        cycle("R8 locked");

        // R8 lock at same edge as strobe (fresh reset)
        idle_inputs();
        do_reset();
        preload_mode = 1;
        cycle("R3 enter preload");
        pin_data = 12'hFFF; eo_sel = 0; qsel = 0; strobe = 1; lock_in = 1;
        cycle("R8 write blocked");

        // R9 sticky
        lock_in = 0; strobe = 0;
        cycle("R9 lock released");
        for (int j = 0; j < 3; j++) begin
            strobe = 1; pin_data = G'($urandom);
            cycle("R9 preload blocked");
            strobe = 0;
            cycle("R9 preload blocked");
        end
        preload_mode = 0; observe_mode = 1;
        cycle("R9 observe blocked");
        cycle("R9 observe blocked");

        // R9 reset clears lock
        idle_inputs();
        do_reset();
        preload_mode = 1;
        cycle("R9 preload after reset");
        pin_data = 12'h9C3; eo_sel = 1; qsel = 0; strobe = 1;
        cycle("R9 write after reset");

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            errs++;
            checks++;
            $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule